// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block is the slave side of a serial configuration port. An external master uses it to read and write a small bank of byte-wide registers. The master drives an active-low chip select, a serial clock and a data line. The data line is bidirectional at the pad and appears here as separate in, out and output-enable signals. A dedicated serial output is also provided. Each transfer begins with a 16-bit instruction word and continues with one or more data bytes. The instruction gives the direction, a byte-count code and a start address. The address steps after every data byte.

Two bits of register 0 select the operating mode. One bit routes read data to the dedicated output instead of the shared data line. The other bit reverses the bit order of both the instruction and the data, and it also makes the address step downward instead of upward. The master may raise chip select between bytes to pause a transfer. Whether that pause is a legal hold or an abort depends on the burst length and on how far the transfer has progressed.

The port runs on the system clock. Chip select, serial clock and data-in pass through a short synchronizer, and the serial clock edges are detected from the synchronized copy. The master's serial clock must therefore be several system clocks per half period.

Top module: `spiRegPort`

## Requirements
- R1: In three-wire mode (register 0 bit 7 clear, the reset state), read data leaves on `sdioOut`. `sdioOe` is high only during the data phase of a read while chip select is low. It is low during the instruction phase and during writes.
- R2: When register 0 bit 7 is set (four-wire mode), read data leaves on `sdoOut` and `sdioOe` stays low for the whole transfer.
- R3: When register 0 bit 6 is clear, instruction and data bits are most-significant bit first. When it is set, both are least-significant bit first: the first bit on the line is instruction bit 0 or data bit 0.
- R4: The instruction word is laid out as follows: bit 15 selects the direction (1 = read, 0 = write), bits 14:13 hold the byte-count code, and bits 12:0 hold the start address. Input bits are sampled on rising serial clock edges, and the first rising edge after chip select falls carries the first instruction bit.
- R5: Count codes 00, 01 and 10 transfer 1, 2 and 3 data bytes. Once that many bytes have been transferred, further clock edges are ignored until chip select rises.
- R6: Count code 11 streams data bytes for as long as chip select stays low.
- R7: After each data byte the address increments in MSB-first order and decrements in LSB-first order. The 13-bit address wraps around at either end.
- R8: In a 1 to 3 byte transfer, chip select may rise at any byte boundary, in either the instruction or the data phase. The transfer continues when chip select falls again.
- R9: In a streaming transfer, chip select may rise between the two instruction bytes or before the first data byte. Raising it after any data byte has completed aborts the transfer. Raising chip select in the middle of any byte always aborts. After an abort, the next low period starts a fresh instruction.
- R10: Each read data bit is launched on a falling serial clock edge and is valid before the next rising edge. The first data bit is launched on the falling edge that follows the last instruction bit.
- R11: Registers exist at addresses 0x000 to 0x00F. Writes to any other 13-bit address change no register, and reads from such an address return 0x00.
- R12: A write to register 0 changes the bit order and the wire mode only after its whole byte has been received. The address step for that byte and all of its bits use the old mode.
- R13: After reset every register reads 0x00, and `sdioOe`, `sdioOut` and `sdoOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiCsN | input | 1 | Chip select from the master, active low |
| spiSclk | input | 1 | Serial clock from the master |
| sdioIn | input | 1 | Input side of the shared data line |
| sdioOut | output | 1 | Output side of the shared data line |
| sdioOe | output | 1 | Drive enable for the shared data line |
| sdoOut | output | 1 | Dedicated serial read output (four-wire mode) |

## Verification
The hardest case to reach from the ports is a write to register 0 that flips the bit order in the middle of a burst. The next byte must then arrive in the new order, while the address step for the byte that caused the change still follows the old order. The bench reaches this case with a two-byte write starting at address 0. Its reference model updates the mode only after each byte has been sent, so the second byte is shifted out LSB-first, and the value that lands in register 1 shows which order the port used. The bench also checks that a streaming pause after a data byte really aborts the transfer. It does this by sending a complete new instruction after the pause and confirming that none of its bits landed in the registers that the stream would have reached next.

// File: rtl/spiRegPkg.sv
package spiRegPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INSTR = 2'd1,
    ST_DATA  = 2'd2,
    ST_DONE  = 2'd3
  } spiState_e;

  // Strobes from control to datapath, one system clock wide each
  typedef struct packed {
    logic       instrShift;  // take one instruction bit
    logic       instrLoad;   // last instruction bit: load the address
    logic       dataShift;   // take one data bit
    logic       dataCommit;  // last data bit: write and step the address
    logic       launch;      // falling edge in data phase: drive next read bit
    logic       dataPhase;   // data phase with chip select low
    logic [2:0] bitIdx;      // bits already taken in the current byte
  } spiStrobe_t;

endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       csLow,
  input  logic [1:0] byteCode,
  output spiStrobe_t strb
);

  localparam logic [2:0] LAST_BIT = 3'd7;
  localparam logic [1:0] STREAM_CODE = 2'b11;

  spiState_e state;
  logic [2:0] bitCnt;
  logic       instrHi;
  logic [1:0] bytesDone;
  logic       anyData;
  logic       streaming;

  assign streaming = (byteCode == STREAM_CODE);

  always_comb begin
    strb            = '0;
    strb.bitIdx     = bitCnt;
    strb.instrShift = (state == ST_INSTR) && csLow && sclkRise;
    strb.instrLoad  = strb.instrShift && (bitCnt == LAST_BIT) && instrHi;
    strb.dataShift  = (state == ST_DATA) && csLow && sclkRise;
    strb.dataCommit = strb.dataShift && (bitCnt == LAST_BIT);
    strb.launch     = (state == ST_DATA) && csLow && sclkFall;
    strb.dataPhase  = (state == ST_DATA) && csLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      instrHi   <= 1'b0;
      bytesDone <= '0;
      anyData   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (csLow) begin
            state     <= ST_INSTR;
            bitCnt    <= '0;
            instrHi   <= 1'b0;
            bytesDone <= '0;
            anyData   <= 1'b0;
          end
        end
        ST_INSTR: begin
          if (!csLow) begin
            if (bitCnt != 3'd0) state <= ST_IDLE;   // cut inside a byte
          end else if (sclkRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == LAST_BIT) begin
              instrHi <= 1'b1;
              if (instrHi) state <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (!csLow) begin
            if (bitCnt != 3'd0 || (streaming && anyData)) state <= ST_IDLE;
          end else if (sclkRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == LAST_BIT) begin
              anyData   <= 1'b1;
              bytesDone <= bytesDone + 2'd1;
              if (!streaming && bytesDone == byteCode) state <= ST_DONE;
            end
          end
        end
        default: begin
          if (!csLow) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R5: the byte count closes the transfer after its last byte
  p_count_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataCommit && !streaming && (bytesDone == byteCode) |=> state == ST_DONE);

  // R9: a stream that already moved data is ended by a chip-select pause
  p_stream_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) && !csLow && streaming && anyData |=> state == ST_IDLE);

  // R9: a pause inside a byte always resets the engine
  p_midbyte_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INSTR || state == ST_DATA) && !csLow && (bitCnt != 3'd0)
      |=> state == ST_IDLE);

endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  spiStrobe_t strb,
  input  logic       sdiBit,
  output logic [1:0] byteCode,
  output logic       sdioOut,
  output logic       sdioOe,
  output logic       sdoOut
);

  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int INSTR_W = 16;
  localparam int BYTE_W  = 8;
  localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(NUM_REGS);

  logic [NUM_REGS-1:0][BYTE_W-1:0] bank;
  logic [INSTR_W-1:0] instrReg, instrNext;
  logic [BYTE_W-1:0]  dataReg, dataNext, rdByte;
  logic [ADDR_W-1:0]  addr;
  logic [IDX_W-1:0]   idx;
  logic               addrHit, msbFirst, fourWire, rdFlag, outBit, readActive;
  logic [2:0]         bitSel;

  assign msbFirst  = ~bank[0][6];
  assign fourWire  = bank[0][7];
  assign rdFlag    = instrReg[15];
  assign byteCode  = instrReg[14:13];

  assign instrNext = msbFirst ? {instrReg[INSTR_W-2:0], sdiBit}
                              : {sdiBit, instrReg[INSTR_W-1:1]};
  assign dataNext  = msbFirst ? {dataReg[BYTE_W-2:0], sdiBit}
                              : {sdiBit, dataReg[BYTE_W-1:1]};

  assign addrHit = (addr < REG_LIMIT);
  assign idx     = addr[IDX_W-1:0];
  assign rdByte  = addrHit ? bank[idx] : '0;
  assign bitSel  = msbFirst ? (3'd7 - strb.bitIdx) : strb.bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bank     <= '0;
      instrReg <= '0;
      dataReg  <= '0;
      addr     <= '0;
      outBit   <= 1'b0;
    end else begin
      if (strb.instrShift) instrReg <= instrNext;
      if (strb.instrLoad)  addr     <= instrNext[ADDR_W-1:0];
      if (strb.dataShift)  dataReg  <= dataNext;
      if (strb.dataCommit) begin
        if (!rdFlag && addrHit) bank[idx] <= dataNext;
        addr <= msbFirst ? addr + 1'b1 : addr - 1'b1;
      end
      if (strb.launch) outBit <= rdByte[bitSel];
    end
  end

  assign readActive = strb.dataPhase && rdFlag;
  assign sdioOe     = readActive && !fourWire;
  assign sdioOut    = sdioOe && outBit;
  assign sdoOut     = readActive && fourWire && outBit;

  // R7: address moves up in MSB-first order
  p_addr_inc_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataCommit && msbFirst |=> addr == $past(addr) + 1'b1);

  // R7: address moves down in LSB-first order
  p_addr_dec_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataCommit && !msbFirst |=> addr == $past(addr) - 1'b1);

  // R11: out-of-range writes leave the bank alone
  p_unimpl_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataCommit && !addrHit |=> $stable(bank));

  // R12: the mode byte only moves on a completed data byte
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dataCommit |=> $stable(bank[0]));

  // R2: four-wire mode never drives the shared line
  p_fourwire_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    fourWire |-> !sdioOe);

  // R1: the shared line is driven only while returning read data
  p_oe_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> rdFlag && strb.dataPhase);

endmodule

// File: rtl/spiRegPort.sv
module spiRegPort
  import spiRegPkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiCsN,
  input  logic spiSclk,
  input  logic sdioIn,
  output logic sdioOut,
  output logic sdioOe,
  output logic sdoOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclkSync, csSync, sdiSync;
  logic          sclkPrev, sclkRise, sclkFall, csLow;
  logic [1:0]    byteCode;
  spiStrobe_t    strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      sdiSync  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[LAST-1:0], spiSclk};
      csSync   <= {csSync[LAST-1:0], spiCsN};
      sdiSync  <= {sdiSync[LAST-1:0], sdioIn};
      sclkPrev <= sclkSync[LAST];
    end
  end

  assign sclkRise = sclkSync[LAST] && !sclkPrev;
  assign sclkFall = !sclkSync[LAST] && sclkPrev;
  assign csLow    = !csSync[LAST];

  spiRegCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkRise (sclkRise),
    .sclkFall (sclkFall),
    .csLow    (csLow),
    .byteCode (byteCode),
    .strb     (strb)
  );

  spiRegDatapath #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sdiBit   (sdiSync[LAST]),
    .byteCode (byteCode),
    .sdioOut  (sdioOut),
    .sdioOe   (sdioOe),
    .sdoOut   (sdoOut)
  );

endmodule

// File: tb/sim_spiRegPort.sv
module sim_spiRegPort;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1;
  logic spiSclk = 1'b0;
  logic sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0]  model [0:15];
  logic        msbM  = 1'b1;
  logic        fourM = 1'b0;
  logic [7:0]  txBuf [0:7];
  logic        instrOe;

  always #5 clk = ~clk;

  spiRegPort u0 (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .sdioIn(sdioIn), .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRd(input logic [12:0] a);
    return (a < 13'd16) ? model[a[3:0]] : 8'h00;
  endfunction

  function automatic logic [12:0] stepAddr(input logic [12:0] a);
    return msbM ? a + 13'd1 : a - 13'd1;
  endfunction

  task automatic csDown();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csUp();
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic got, output logic oe);
    sdioIn = b;
    repeat (HALF) @(negedge clk);
    got = fourM ? sdoOut : sdioOut;
    oe  = sdioOe;
    spiSclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spiSclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic [7:0] rx,
                          output logic oeAny, output logic oeAll);
    logic g, o;
    oeAny = 1'b0;
    oeAll = 1'b1;
    rx = '0;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = msbM ? 7 - i : i;
      sendBit(v[k], g, o);
      rx[k] = g;
      oeAny |= o;
      oeAll &= o;
    end
  endtask

  task automatic sendInstr(input logic rw, input logic [1:0] code,
                           input logic [12:0] a, input logic pause);
    logic [15:0] w;
    logic g, o;
    w = {rw, code, a};
    instrOe = 1'b0;
    for (int i = 0; i < 16; i++) begin
      int k;
      k = msbM ? 15 - i : i;
      sendBit(w[k], g, o);
      instrOe |= o;
      if (pause && i == 7) begin
        csUp();
        csDown();
      end
    end
  endtask

  // Write n bytes from txBuf; the model applies mode changes after each byte
  task automatic doWrite(input logic [12:0] a, input logic [1:0] code,
                         input int n, input logic pause);
    logic [7:0] rx;
    logic oa, ol;
    logic [12:0] cur;
    cur = a;
    csDown();
    sendInstr(1'b0, code, a, pause);
    for (int b = 0; b < n; b++) begin
      sendByte(txBuf[b], rx, oa, ol);
      chk("R1 no drive during write", {31'd0, oa}, 32'd0);
      if (cur < 13'd16) model[cur[3:0]] = txBuf[b];
      if (cur == 13'd0) begin
        cur = stepAddr(cur);
        msbM  = ~txBuf[b][6];
        fourM = txBuf[b][7];
      end else begin
        cur = stepAddr(cur);
      end
      if (pause && b != n - 1) begin
        csUp();
        csDown();
      end
    end
    csUp();
  endtask

  task automatic doRead(input string req, input logic [12:0] a,
                        input logic [1:0] code, input int n);
    logic [7:0] rx;
    logic oa, ol;
    logic [12:0] cur;
    cur = a;
    csDown();
    sendInstr(1'b1, code, a, 1'b0);
    chk({req, " R1 no drive in instruction"}, {31'd0, instrOe}, 32'd0);
    for (int b = 0; b < n; b++) begin
      sendByte(8'h00, rx, oa, ol);
      chk({req, " R10 read byte"}, {24'd0, rx}, {24'd0, modelRd(cur)});
      if (fourM) chk({req, " R2 shared line idle"}, {31'd0, oa}, 32'd0);
      else       chk({req, " R1 drive during read"}, {31'd0, ol}, 32'd1);
      cur = stepAddr(cur);
    end
    csUp();
  endtask

  task automatic t_reset();
    chk("R13 oe after reset", {31'd0, sdioOe}, 32'd0);
    chk("R13 sdio after reset", {31'd0, sdioOut}, 32'd0);
    chk("R13 sdo after reset", {31'd0, sdoOut}, 32'd0);
    doRead("R13", 13'h000, 2'b10, 3);
  endtask

  task automatic t_single();
    txBuf[0] = 8'hA5;
    doWrite(13'h005, 2'b00, 1, 1'b0);
    doRead("R4", 13'h005, 2'b00, 1);
  endtask

  task automatic t_extraClocks();
    logic [7:0] rx;
    logic oa, ol;
    csDown();
    sendInstr(1'b0, 2'b00, 13'h006, 1'b0);
    sendByte(8'h3C, rx, oa, ol);
    model[6] = 8'h3C;
    sendByte(8'hFF, rx, oa, ol);  // beyond the count: must be ignored
    csUp();
    doRead("R5", 13'h006, 2'b01, 2);
  endtask

  task automatic t_burst3();
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33;
    doWrite(13'h008, 2'b10, 3, 1'b0);
    doRead("R7 inc", 13'h008, 2'b10, 3);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 5; i++) txBuf[i] = 8'hC0 + 8'(i);
    doWrite(13'h00A, 2'b11, 5, 1'b0);
    doRead("R6", 13'h00A, 2'b11, 5);
    doRead("R11 edge", 13'h00E, 2'b11, 4);
  endtask

  task automatic t_unimpl();
    txBuf[0] = 8'h77;
    doWrite(13'h020, 2'b00, 1, 1'b0);
    doRead("R11 far", 13'h020, 2'b00, 1);
    txBuf[0] = 8'h99;
    doWrite(13'h1003, 2'b00, 1, 1'b0);
    doRead("R11 alias", 13'h003, 2'b00, 1);
    doRead("R11 low", 13'h000, 2'b10, 3);
  endtask

  task automatic t_pause3();
    txBuf[0] = 8'h5C; txBuf[1] = 8'hE1; txBuf[2] = 8'h0F;
    doWrite(13'h001, 2'b10, 3, 1'b1);
    doRead("R8", 13'h001, 2'b10, 3);
  endtask

  task automatic t_streamAbort();
    logic [7:0] rx;
    logic oa, ol, g, o;
    csDown();
    sendInstr(1'b0, 2'b11, 13'h004, 1'b1);
    csUp();                       // allowed: before the first data byte
    csDown();
    sendByte(8'h4A, rx, oa, ol);
    sendByte(8'h4B, rx, oa, ol);
    model[4] = 8'h4A; model[5] = 8'h4B;
    csUp();                       // after data: aborts
    csDown();
    sendInstr(1'b0, 2'b00, 13'h00C, 1'b0);
    sendByte(8'h5A, rx, oa, ol);
    model[12] = 8'h5A;
    csUp();
    doRead("R9 stream", 13'h004, 2'b10, 3);
    doRead("R9 new", 13'h00C, 2'b00, 1);
    csDown();                     // cut inside the instruction
    for (int i = 0; i < 4; i++) sendBit(1'b1, g, o);
    csUp();
    txBuf[0] = 8'h66;
    doWrite(13'h00D, 2'b00, 1, 1'b0);
    doRead("R9 midbyte", 13'h00D, 2'b00, 1);
  endtask

  task automatic t_lsb();
    txBuf[0] = 8'h40;
    doWrite(13'h000, 2'b00, 1, 1'b0);
    chk("R3 mode model", {31'd0, msbM}, 32'd0);
    txBuf[0] = 8'h81; txBuf[1] = 8'h7E;
    doWrite(13'h009, 2'b01, 2, 1'b0);
    doRead("R3 R7 dec", 13'h009, 2'b01, 2);
    txBuf[0] = 8'h00;
    doWrite(13'h000, 2'b00, 1, 1'b0);
    doRead("R3 back", 13'h008, 2'b00, 1);
  endtask

  task automatic t_modeMid();
    txBuf[0] = 8'h40; txBuf[1] = 8'h96;  // second byte goes out LSB-first
    doWrite(13'h000, 2'b01, 2, 1'b0);
    doRead("R12", 13'h001, 2'b00, 1);
    txBuf[0] = 8'h00;
    doWrite(13'h000, 2'b00, 1, 1'b0);
    doRead("R12 restore", 13'h000, 2'b01, 2);
  endtask

  task automatic t_four();
    txBuf[0] = 8'h80;
    doWrite(13'h000, 2'b00, 1, 1'b0);
    doRead("R2", 13'h005, 2'b01, 2);
    txBuf[0] = 8'h00;
    doWrite(13'h000, 2'b00, 1, 1'b0);
    doRead("R2 restore", 13'h005, 2'b00, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_extraClocks();
    t_burst3();
    t_stream();
    t_unimpl();
    t_pause3();
    t_streamAbort();
    t_lsb();
    t_modeMid();
    t_four();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule